// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer Counter

This block is a 16-bit counter that advances on tick strobes. All logic runs in one clock domain, and each clock source reaches the block as a one-cycle enable pulse. A 2-bit select chooses one of four tick inputs: two internal clocks and two external ones. A 2-bit mode field, which can change at run time, picks one of four behaviours:
- **Halted:** the count holds.
- **Bounded up:** the count climbs from zero to a programmed limit, then restarts at zero.
- **Free-running:** the count covers the whole 16-bit range.
- **Triangle:** the count climbs from zero to the limit and falls back to zero.

A sticky event flag records each period completion. The flag is gated by an enable to form the interrupt output.

Software sets up the block as follows:
1. Load the limit with a one-cycle write strobe.
2. Choose the source and the mode.
3. Read the count at any time.
4. Clear the flag after it has served the interrupt.

A clear strobe restarts the count from zero without changing the mode.

Top module: `modal_timer`

## Requirements
- R1: After a synchronous reset the count is 0, the flag is 0, the irq output is 0 and the stored limit is 0.
- R2: `src_sel` chooses the tick source: 0 selects `tick_int0`, 1 selects `tick_int1`, 2 selects `tick_ext0` and 3 selects `tick_ext1`. Pulses on the three sources that are not selected leave the count unchanged.
- R3: With `mode` = 0 (halted) the count holds its value while ticks arrive.
- R4: With `mode` = 1 (bounded up) each tick adds one to the count until the count equals the limit. The tick after that loads 0 and sets the flag. If the count is already above a newly written limit, the next tick also loads 0 and sets the flag.
- R5: With `mode` = 2 (free-running) each tick adds one to the count. A tick at 0xFFFF loads 0 and sets the flag. No other tick sets the flag in this mode.
- R6: With `mode` = 3 (triangle) the count rises to the limit and then falls one step per tick. The flag is set on the tick that brings the falling count to 0. The next tick moves the count to 1.
- R7: With a limit of 0 in mode 1 or mode 3, a tick forces the count to 0 and sets no flag.
- R8: `clr` has priority over a tick. In one cycle it sets the count to 0 and the direction to upward.
- R9: The flag stays set until `flag_clr` is pulsed. If an event and `flag_clr` occur in the same cycle, the flag remains set.
- R10: `irq` is high exactly when the flag and `irq_en` are both high. A change of `irq_en` takes effect in the same cycle.
- R11: The count changes only on a cycle in which the selected source ticks or `clr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Tick source select |
| tick_int0 | input | 1 | Internal clock tick strobe 0 |
| tick_int1 | input | 1 | Internal clock tick strobe 1 |
| tick_ext0 | input | 1 | External clock tick strobe 0 |
| tick_ext1 | input | 1 | External clock tick strobe 1 |
| mode | input | 2 | 0 halted, 1 bounded up, 2 free-running, 3 triangle |
| limit_wr | input | 1 | Write strobe for the limit register |
| limit_in | input | 16 | New limit value |
| clr | input | 1 | Restart the count from 0, direction upward |
| flag_clr | input | 1 | Clear the event flag |
| irq_en | input | 1 | Interrupt enable |
| count | output | 16 | Current count |
| flag | output | 1 | Sticky period event flag |
| irq | output | 1 | Flag gated by the enable |

## Verification
Each mode is tried with its own tick pattern, and each pattern exposes a different fault:
- **Bounded up, limit 3:** short single pulses tell an off-by-one wrap apart from a correct one.
- **Triangle, limit 2:** the walk 1,2,1,0,1 separates a flag raised at the top of the climb from one raised at the bottom.
- **Free-running:** a long run of back-to-back ticks reaches 0xFFFF and shows that the flag is raised only at the full-range wrap.

Further directed patterns cover the remaining rules:
- Pulses on each source that is not selected show whether the select decoding is correct.
- A clear during the falling phase exposes a direction that was not reset.
- A limit lowered below the count shows whether the comparison is "greater or equal" rather than "equal".

// File: rtl/modal_timer_pkg.sv
package modal_timer_pkg;
  typedef enum logic [1:0] {
    MD_HALT = 2'd0,
    MD_UP   = 2'd1,
    MD_FREE = 2'd2,
    MD_TRI  = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/tick_select.sv
module tick_select #(
  parameter int NSRC = 4,
  localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] ticks,
  input  logic [SELW-1:0] sel,
  output logic            tick
);
  logic [NSRC-1:0] hit;
  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      assign hit[g] = ticks[g] && (sel == SELW'(g));
    end
  endgenerate
  assign tick = |hit;
endmodule

// File: rtl/count_engine.sv
module count_engine
  import modal_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         clr,
  input  tmr_mode_e    mode,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         wrap_ev
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         dn_q, dn_d;
  logic         ev;

  always_comb begin
    cnt_d = cnt_q;
    dn_d  = (mode == MD_TRI) ? dn_q : 1'b0;
    ev    = 1'b0;
    if (clr) begin
      cnt_d = '0;
      dn_d  = 1'b0;
    end else if (tick) begin
      unique case (mode)
        MD_UP: begin
          if (limit == '0) begin
            cnt_d = '0;
          end else if (cnt_q >= limit) begin
            cnt_d = '0;
            ev    = 1'b1;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        MD_FREE: begin
          cnt_d = cnt_q + ONE;
          ev    = (cnt_q == TOP);
        end
        MD_TRI: begin
          if (limit == '0) begin
            cnt_d = '0;
            dn_d  = 1'b0;
          end else if (dn_q || (cnt_q >= limit)) begin
            cnt_d = cnt_q - ONE;
            if (cnt_q == ONE) begin
              ev   = 1'b1;
              dn_d = 1'b0;
            end else begin
              dn_d = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + ONE;
            dn_d  = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
    end
  end

  assign count   = cnt_q;
  assign wrap_ev = ev;
endmodule

// File: rtl/event_flag.sv
module event_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (set_ev)  flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end
endmodule

// File: rtl/modal_timer.sv
module modal_timer
  import modal_timer_pkg::*;
#(
  parameter int W    = 16,
  parameter int NSRC = 4,
  localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SELW-1:0] src_sel,
  input  logic            tick_int0,
  input  logic            tick_int1,
  input  logic            tick_ext0,
  input  logic            tick_ext1,
  input  logic [1:0]      mode,
  input  logic            limit_wr,
  input  logic [W-1:0]    limit_in,
  input  logic            clr,
  input  logic            flag_clr,
  input  logic            irq_en,
  output logic [W-1:0]    count,
  output logic            flag,
  output logic            irq
);
  logic [W-1:0] limit_q;
  logic         tick_w;
  logic         wrap_w;
  logic [3:0]   src_vec;

  assign src_vec = {tick_ext1, tick_ext0, tick_int1, tick_int0};

  always_ff @(posedge clk) begin
    if (rst)           limit_q <= '0;
    else if (limit_wr) limit_q <= limit_in;
  end

  tick_select #(.NSRC(NSRC)) u_sel (
    .ticks (src_vec[NSRC-1:0]),
    .sel   (src_sel),
    .tick  (tick_w)
  );

  count_engine #(.W(W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_w),
    .clr     (clr),
    .mode    (tmr_mode_e'(mode)),
    .limit   (limit_q),
    .count   (count),
    .wrap_ev (wrap_w)
  );

  event_flag u_flag (
    .clk     (clk),
    .rst     (rst),
    .set_ev  (wrap_w),
    .clr_req (flag_clr),
    .flag    (flag)
  );

  assign irq = flag & irq_en;
endmodule

// File: rtl/modal_timer_chk.sv
module modal_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         tick_w,
  input logic         clr,
  input logic         flag_clr,
  input logic [1:0]   mode,
  input logic [W-1:0] limit_q,
  input logic [W-1:0] count,
  input logic         flag
);
  // R3
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && !clr) |=> $stable(count));

  // R11
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_w && !clr) |=> $stable(count));

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag);

  // R5
  free_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && tick_w && !clr && count == '1) |=> (count == '0 && flag));

  // R4
  up_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && tick_w && !clr && limit_q != '0 && count < limit_q)
    |=> (count == $past(count) + W'(1)));

  // R7
  zero_limit_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode == 2'd1 || mode == 2'd3) && tick_w && !clr && limit_q == '0)
    |=> (count == '0));
endmodule

bind modal_timer modal_timer_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_w   (tick_w),
  .clr      (clr),
  .flag_clr (flag_clr),
  .mode     (mode),
  .limit_q  (limit_q),
  .count    (count),
  .flag     (flag)
);

// File: tb/modal_timer_tb.sv
`timescale 1ns/1ps
module modal_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  src_sel = 2'd0;
  logic [3:0]  tk = 4'd0;
  logic [1:0]  mode = 2'd0;
  logic        limit_wr = 1'b0;
  logic [15:0] limit_in = 16'd0;
  logic        clr = 1'b0;
  logic        flag_clr = 1'b0;
  logic        irq_en = 1'b0;
  logic [15:0] count;
  logic        flag;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  modal_timer dut_i (
    .clk(clk), .rst(rst), .src_sel(src_sel),
    .tick_int0(tk[0]), .tick_int1(tk[1]), .tick_ext0(tk[2]), .tick_ext1(tk[3]),
    .mode(mode), .limit_wr(limit_wr), .limit_in(limit_in), .clr(clr),
    .flag_clr(flag_clr), .irq_en(irq_en), .count(count), .flag(flag), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_src(input int idx);
    @(negedge clk) tk[idx] = 1'b1;
    @(negedge clk) tk[idx] = 1'b0;
  endtask

  task automatic pulse();
    pulse_src(int'(src_sel));
  endtask

  task automatic set_limit(input logic [15:0] v);
    @(negedge clk) begin limit_wr = 1'b1; limit_in = v; end
    @(negedge clk) limit_wr = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk) begin clr = 1'b1; flag_clr = 1'b1; end
    @(negedge clk) begin clr = 1'b0; flag_clr = 1'b0; end
  endtask

  task automatic t_reset();
    check("R1 count", count, 0);
    check("R1 flag", flag, 0);
    check("R1 irq", irq, 0);
    mode = 2'd1;
    pulse();
    check("R1 limit zero after reset", count, 0);
    mode = 2'd0;
  endtask

  task automatic t_source();
    mode = 2'd1;
    set_limit(16'd100);
    do_clr();
    for (int s = 0; s < 4; s++) begin
      src_sel = 2'(s);
      for (int o = 0; o < 4; o++) if (o != s) pulse_src(o);
      check("R2 unselected ignored", count, s);
      pulse_src(s);
      check("R2 selected counts", count, s + 1);
    end
    src_sel = 2'd0;
  endtask

  task automatic t_halt();
    mode = 2'd0;
    repeat (3) pulse();
    check("R3 halted holds", count, 4);
  endtask

  task automatic t_up();
    mode = 2'd1;
    set_limit(16'd3);
    do_clr();
    pulse(); check("R4 step1", count, 1);
    pulse(); pulse(); check("R4 at limit", count, 3);
    check("R4 no flag before wrap", flag, 0);
    pulse(); check("R4 wrap to 0", count, 0);
    check("R4 flag on wrap", flag, 1);
    set_limit(16'd10);
    do_clr();
    repeat (5) pulse();
    set_limit(16'd2);
    pulse();
    check("R4 above new limit rolls", count, 0);
    check("R4 roll flag", flag, 1);
  endtask

  task automatic t_free();
    mode = 2'd2;
    do_clr();
    @(negedge clk) tk[0] = 1'b1;
    repeat (65535) @(negedge clk);
    tk[0] = 1'b0;
    check("R5 reaches top", count, 16'hFFFF);
    check("R5 no early flag", flag, 0);
    pulse();
    check("R5 wraps", count, 0);
    check("R5 flag", flag, 1);
  endtask

  task automatic t_tri();
    mode = 2'd3;
    set_limit(16'd2);
    do_clr();
    pulse(); pulse(); check("R6 peak", count, 2);
    pulse(); check("R6 falling", count, 1);
    check("R6 no flag at peak", flag, 0);
    pulse(); check("R6 bottom", count, 0);
    check("R6 flag at bottom", flag, 1);
    pulse(); check("R6 rises again", count, 1);
  endtask

  task automatic t_zero_limit();
    set_limit(16'd0);
    mode = 2'd1; do_clr();
    repeat (3) pulse();
    check("R7 up zero limit count", count, 0);
    check("R7 up zero limit flag", flag, 0);
    mode = 2'd3;
    repeat (3) pulse();
    check("R7 tri zero limit count", count, 0);
    check("R7 tri zero limit flag", flag, 0);
  endtask

  task automatic t_clear();
    mode = 2'd3;
    set_limit(16'd3);
    do_clr();
    repeat (4) pulse();
    check("R8 falling before clr", count, 2);
    @(negedge clk) begin clr = 1'b1; tk[0] = 1'b1; end
    @(negedge clk) begin clr = 1'b0; tk[0] = 1'b0; end
    check("R8 clr beats tick", count, 0);
    pulse();
    check("R8 direction upward", count, 1);
  endtask

  task automatic t_flag_irq();
    mode = 2'd1;
    set_limit(16'd1);
    do_clr();
    pulse();
    @(negedge clk) begin tk[0] = 1'b1; flag_clr = 1'b1; end
    @(negedge clk) begin tk[0] = 1'b0; flag_clr = 1'b0; end
    check("R9 set wins over clear", flag, 1);
    repeat (2) pulse();
    check("R9 sticky", flag, 1);
    irq_en = 1'b0; #1;
    check("R10 gated off", irq, 0);
    irq_en = 1'b1; #1;
    check("R10 gated on", irq, 1);
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    check("R9 cleared", flag, 0);
    check("R10 irq drops", irq, 0);
  endtask

  task automatic t_idle();
    mode = 2'd2;
    do_clr();
    pulse();
    repeat (5) @(negedge clk);
    check("R11 holds without tick", count, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_source();
    t_halt();
    t_up();
    t_tri();
    t_zero_limit();
    t_clear();
    t_flag_irq();
    t_idle();
    t_free();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule